// File: doc/BRIEF.md
# Sixteen-Bit ALU with Separate Arithmetic and Compare Flags

This block is the arithmetic and logic unit of a small RISC core. It takes two register operands and an operation code. It produces a registered 16-bit result and keeps two independent groups of condition flags. Each group holds carry, zero, sign and overflow.

The arithmetic group holds the multiword state. Add-with-carry, subtract-with-borrow and the one-bit shifts through carry read it and write it. The compare group is written only by the compare and test operations. Flag-setting arithmetic can therefore sit between a compare and the branch that uses it without disturbing that compare.

A branch selector picks one of the two groups. A condition code then picks the test to apply to that group. The resulting `condTrue` is combinational and is evaluated from the flags currently held.

Top module: `dualflag_alu`

## Requirements
- R1: During reset and at its release, `result` is 0, `resultValid` is 0, and both flag groups are 0. Flag vectors are laid out as bit0 carry, bit1 zero, bit2 sign, bit3 overflow.
- R2: Opcode 0 (ADD) stores A+B into `result` one clock after `valid`. It writes all four arithmetic flags. Carry is the carry out of bit 15. Overflow is the carry into bit 15 XOR the carry out of bit 15.
- R3: Opcode 2 (SUB) stores A-B. Carry is written as NOT borrow, so carry is 1 when A >= B unsigned. Zero, sign and overflow are written as for ADD.
- R4: Opcode 1 (ADC) computes A+B+C, and opcode 3 (SBB) computes A+~B+C. Both take C only from the arithmetic carry, never from the compare carry, and both write all four arithmetic flags.
- R5: Opcodes 4 (MOV, result B), 5 (AND), 6 (OR), 7 (XOR) and 8 (NOT, result ~B) write only arithmetic zero and sign. Arithmetic carry and overflow keep their values.
- R6: Opcode 9 (SHL) gives {A[14:0], C} and writes A[15] into carry. Opcode 10 (SHR) gives {C, A[15:1]} and writes A[0] into carry. Both also write zero and sign, and both keep overflow.
- R7: After every result-producing operation, `resultValid` is 1 for one cycle, arithmetic sign equals result bit 15, and arithmetic zero is 1 exactly when the result is 0.
- R8: Opcode 11 (CMP) computes A-B and writes all four compare flags using the SUB rules. It leaves `result` and the arithmetic flags unchanged.
- R9: Opcode 12 (TST) computes A AND B. It writes compare zero and sign from that value and clears compare carry and compare overflow. It leaves `result` and the arithmetic flags unchanged.
- R10: With `condSel` at 0, `condTrue` is evaluated on the arithmetic flags. With `condSel` at 1, it is evaluated on the compare flags.
- R11: The condition codes are:
  - 0: zero
  - 1: not zero
  - 2: carry
  - 3: not carry
  - 4: sign
  - 5: not sign
  - 6: overflow
  - 7: sign XOR overflow (signed less-than)
  - 8: its inverse (signed greater-or-equal)
  - 9 to 15: always false
- R12: Opcodes 13 to 15, and any opcode presented with `valid` low, change neither `result` nor either flag group, and `resultValid` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| valid | input | 1 | Operation present this cycle |
| opCode | input | 4 | Operation select |
| opA | input | 16 | First register operand |
| opB | input | 16 | Second register operand |
| condSel | input | 1 | Flag group for condition test (0 arithmetic, 1 compare) |
| condCode | input | 4 | Condition to evaluate |
| result | output | 16 | Registered result |
| resultValid | output | 1 | Result written in the previous cycle |
| arithFlags | output | 4 | Arithmetic flag group {V,N,Z,C} |
| cmpFlags | output | 4 | Compare flag group {V,N,Z,C} |
| condTrue | output | 1 | Selected condition holds |

## Verification
The hardest situation to reach is a chain in which the two groups hold opposite carries. In that chain a compare lands between a carry-producing add and a dependent add-with-carry. The stimulus first clears the arithmetic carry and then runs a compare that sets the compare carry. The add-with-carry that follows must still see the cleared carry.

A second hard case comes from logic and shift operations. They must leave overflow intact, so the stimulus first forces arithmetic carry and overflow high with an overflowing add. It then checks that logic operations keep both flags set and that shifts keep overflow set. With the two groups deliberately disagreeing, conditions are then read from both groups.

// File: rtl/dfalu_pkg.sv
package dfalu_pkg;

  localparam int unsigned OP_W   = 4;
  localparam int unsigned COND_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 4'd0,
    OP_ADC = 4'd1,
    OP_SUB = 4'd2,
    OP_SBB = 4'd3,
    OP_MOV = 4'd4,
    OP_AND = 4'd5,
    OP_OR  = 4'd6,
    OP_XOR = 4'd7,
    OP_NOT = 4'd8,
    OP_SHL = 4'd9,
    OP_SHR = 4'd10,
    OP_CMP = 4'd11,
    OP_TST = 4'd12
  } aluOp_e;

  typedef enum logic [COND_W-1:0] {
    CC_EQ = 4'd0,
    CC_NE = 4'd1,
    CC_CS = 4'd2,
    CC_CC = 4'd3,
    CC_MI = 4'd4,
    CC_PL = 4'd5,
    CC_VS = 4'd6,
    CC_LT = 4'd7,
    CC_GE = 4'd8
  } cond_e;

  typedef enum logic [1:0] {
    UNIT_ADD   = 2'd0,
    UNIT_LOGIC = 2'd1,
    UNIT_SHIFT = 2'd2
  } unit_e;

  typedef enum logic [1:0] {
    LS_PASS = 2'd0,
    LS_AND  = 2'd1,
    LS_OR   = 2'd2,
    LS_XOR  = 2'd3
  } logicSel_e;

  // Flag group, bit0 carry .. bit3 overflow
  typedef struct packed {
    logic v;
    logic n;
    logic z;
    logic c;
  } flags_t;

  // Strobes from control to datapath
  typedef struct packed {
    unit_e     unit;
    logicSel_e logicSel;
    logic      invB;
    logic      cinFromFlag;
    logic      cinConst;
    logic      shiftRight;
    logic      wrResult;
    logic      wrArithC;
    logic      wrArithV;
    logic      wrArithZN;
    logic      wrCmp;
    logic      tstMode;
  } strobes_t;

endpackage

// File: rtl/dfalu_ctrl.sv
module dfalu_ctrl
  import dfalu_pkg::*;
(
  input  logic            valid,
  input  logic [OP_W-1:0] opCode,
  output strobes_t        strb
);

  always_comb begin
    strb = '0;
    if (valid) begin
      case (opCode)
        OP_ADD, OP_ADC, OP_SUB, OP_SBB: begin
          strb.unit        = UNIT_ADD;
          strb.invB        = (opCode == OP_SUB) || (opCode == OP_SBB);
          strb.cinFromFlag = (opCode == OP_ADC) || (opCode == OP_SBB);
          strb.cinConst    = (opCode == OP_SUB);
          strb.wrResult    = 1'b1;
          strb.wrArithC    = 1'b1;
          strb.wrArithV    = 1'b1;
          strb.wrArithZN   = 1'b1;
        end
        OP_MOV, OP_NOT, OP_AND, OP_OR, OP_XOR: begin
          strb.unit      = UNIT_LOGIC;
          strb.invB      = (opCode == OP_NOT);
          strb.logicSel  = (opCode == OP_AND) ? LS_AND :
                           (opCode == OP_OR)  ? LS_OR  :
                           (opCode == OP_XOR) ? LS_XOR : LS_PASS;
          strb.wrResult  = 1'b1;
          strb.wrArithZN = 1'b1;
        end
        OP_SHL, OP_SHR: begin
          strb.unit       = UNIT_SHIFT;
          strb.shiftRight = (opCode == OP_SHR);
          strb.wrResult   = 1'b1;
          strb.wrArithC   = 1'b1;
          strb.wrArithZN  = 1'b1;
        end
        OP_CMP: begin
          strb.unit     = UNIT_ADD;
          strb.invB     = 1'b1;
          strb.cinConst = 1'b1;
          strb.wrCmp    = 1'b1;
        end
        OP_TST: begin
          strb.unit     = UNIT_LOGIC;
          strb.logicSel = LS_AND;
          strb.wrCmp    = 1'b1;
          strb.tstMode  = 1'b1;
        end
        default: strb = '0;
      endcase
    end
  end

endmodule

// File: rtl/dfalu_cond.sv
module dfalu_cond
  import dfalu_pkg::*;
(
  input  flags_t            arithF,
  input  flags_t            cmpF,
  input  logic              condSel,
  input  logic [COND_W-1:0] condCode,
  output logic              condTrue
);

  flags_t selF;

  assign selF = condSel ? cmpF : arithF;

  always_comb begin
    case (condCode)
      CC_EQ:   condTrue = selF.z;
      CC_NE:   condTrue = ~selF.z;
      CC_CS:   condTrue = selF.c;
      CC_CC:   condTrue = ~selF.c;
      CC_MI:   condTrue = selF.n;
      CC_PL:   condTrue = ~selF.n;
      CC_VS:   condTrue = selF.v;
      CC_LT:   condTrue = selF.n ^ selF.v;
      CC_GE:   condTrue = ~(selF.n ^ selF.v);
      default: condTrue = 1'b0;
    endcase
  end

endmodule

// File: rtl/dfalu_datapath.sv
module dfalu_datapath
  import dfalu_pkg::*;
#(
  parameter int unsigned DATA_W = 16
)(
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strb,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] result,
  output logic              resultValid,
  output flags_t            arithQ,
  output flags_t            cmpQ
);

  localparam int unsigned LOW_W = DATA_W - 1;

  logic [DATA_W-1:0] bOp;
  logic [DATA_W-1:0] logicRes;
  logic [DATA_W-1:0] shiftRes;
  logic [DATA_W-1:0] aluRes;
  logic [DATA_W:0]   fullSum;
  logic [LOW_W:0]    lowSum;
  logic              carryIn;
  logic              carryIntoTop;
  logic              carryOut;
  logic              ovf;
  logic              shiftOut;
  logic              resZero;
  logic              resNeg;

  assign bOp     = strb.invB ? ~opB : opB;
  assign carryIn = strb.cinFromFlag ? arithQ.c : strb.cinConst;

  // Low slice sum gives the carry into the top bit
  assign lowSum  = {1'b0, opA[LOW_W-1:0]} + {1'b0, bOp[LOW_W-1:0]}
                 + {{LOW_W{1'b0}}, carryIn};
  assign fullSum = {1'b0, opA} + {1'b0, bOp} + {{DATA_W{1'b0}}, carryIn};

  assign carryIntoTop = lowSum[LOW_W];
  assign carryOut     = fullSum[DATA_W];
  assign ovf          = carryIntoTop ^ carryOut;

  always_comb begin
    case (strb.logicSel)
      LS_AND:  logicRes = opA & bOp;
      LS_OR:   logicRes = opA | bOp;
      LS_XOR:  logicRes = opA ^ bOp;
      default: logicRes = bOp;
    endcase
  end

  always_comb begin
    if (strb.shiftRight) begin
      shiftRes = {arithQ.c, opA[DATA_W-1:1]};
      shiftOut = opA[0];
    end else begin
      shiftRes = {opA[DATA_W-2:0], arithQ.c};
      shiftOut = opA[DATA_W-1];
    end
  end

  always_comb begin
    case (strb.unit)
      UNIT_LOGIC: aluRes = logicRes;
      UNIT_SHIFT: aluRes = shiftRes;
      default:    aluRes = fullSum[DATA_W-1:0];
    endcase
  end

  assign resZero = (aluRes == '0);
  assign resNeg  = aluRes[DATA_W-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      result      <= '0;
      resultValid <= 1'b0;
      arithQ      <= '0;
      cmpQ        <= '0;
    end else begin
      resultValid <= strb.wrResult;
      if (strb.wrResult) result <= aluRes;
      if (strb.wrArithZN) begin
        arithQ.z <= resZero;
        arithQ.n <= resNeg;
      end
      if (strb.wrArithC) arithQ.c <= (strb.unit == UNIT_SHIFT) ? shiftOut : carryOut;
      if (strb.wrArithV) arithQ.v <= ovf;
      if (strb.wrCmp) begin
        cmpQ.z <= resZero;
        cmpQ.n <= resNeg;
        cmpQ.c <= strb.tstMode ? 1'b0 : carryOut;
        cmpQ.v <= strb.tstMode ? 1'b0 : ovf;
      end
    end
  end

endmodule

// File: rtl/dualflag_alu.sv
module dualflag_alu
  import dfalu_pkg::*;
#(
  parameter int unsigned DATA_W = 16
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              valid,
  input  logic [OP_W-1:0]   opCode,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              condSel,
  input  logic [COND_W-1:0] condCode,
  output logic [DATA_W-1:0] result,
  output logic              resultValid,
  output logic [3:0]        arithFlags,
  output logic [3:0]        cmpFlags,
  output logic              condTrue
);

  strobes_t strb;
  flags_t   arithQ;
  flags_t   cmpQ;

  dfalu_ctrl i_ctrl (
    .valid  (valid),
    .opCode (opCode),
    .strb   (strb)
  );

  dfalu_datapath #(.DATA_W(DATA_W)) i_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .opA         (opA),
    .opB         (opB),
    .result      (result),
    .resultValid (resultValid),
    .arithQ      (arithQ),
    .cmpQ        (cmpQ)
  );

  dfalu_cond i_cond (
    .arithF   (arithQ),
    .cmpF     (cmpQ),
    .condSel  (condSel),
    .condCode (condCode),
    .condTrue (condTrue)
  );

  assign arithFlags = arithQ;
  assign cmpFlags   = cmpQ;

endmodule

// File: rtl/dfalu_checker.sv
module dfalu_checker #(
  parameter int unsigned DATA_W = 16
)(
  input logic              clk,
  input logic              rstN,
  input logic              valid,
  input logic [3:0]        opCode,
  input logic [DATA_W-1:0] opA,
  input logic [DATA_W-1:0] opB,
  input logic              condSel,
  input logic [3:0]        condCode,
  input logic [DATA_W-1:0] result,
  input logic              resultValid,
  input logic [3:0]        arithFlags,
  input logic [3:0]        cmpFlags,
  input logic              condTrue
);

  assert_cmp_group_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (valid && opCode != 4'd11 && opCode != 4'd12) |=> $stable(cmpFlags));

  assert_logic_keeps_cv_R5: assert property (@(posedge clk) disable iff (!rstN)
    (valid && opCode >= 4'd4 && opCode <= 4'd8) |=>
      (arithFlags[0] == $past(arithFlags[0]) && arithFlags[3] == $past(arithFlags[3])));

  assert_sign_zero_track_R7: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> (arithFlags[2] == result[DATA_W-1] && arithFlags[1] == (result == '0)));

  assert_shl_carry_R6: assert property (@(posedge clk) disable iff (!rstN)
    (valid && opCode == 4'd9) |=>
      (arithFlags[0] == $past(opA[DATA_W-1]) && result[0] == $past(arithFlags[0])));

  assert_reserved_ignored_R12: assert property (@(posedge clk) disable iff (!rstN)
    (valid && opCode >= 4'd13) |=>
      ($stable(result) && $stable(arithFlags) && $stable(cmpFlags) && !resultValid));

endmodule

bind dualflag_alu dfalu_checker #(.DATA_W(DATA_W)) i_chk (.*);

// File: tb/test_dualflag_alu.sv
module test_dualflag_alu;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        valid = 1'b0;
  logic [3:0]  opCode = 4'd0;
  logic [15:0] opA = 16'd0;
  logic [15:0] opB = 16'd0;
  logic        condSel = 1'b0;
  logic [3:0]  condCode = 4'd0;
  logic [15:0] result;
  logic        resultValid;
  logic [3:0]  arithFlags;
  logic [3:0]  cmpFlags;
  logic        condTrue;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Reference state, layout {V,N,Z,C}
  logic [15:0] mRes   = 16'd0;
  logic        mValid = 1'b0;
  logic [3:0]  mArith = 4'd0;
  logic [3:0]  mCmp   = 4'd0;

  logic [36:0] expQ[$];
  string       tagQ[$];

  always #4 clk = ~clk;

  dualflag_alu i_dualflag_alu (.*);

  task automatic modelStep(input logic vld, input logic [3:0] op,
                           input logic [15:0] a, input logic [15:0] b);
    logic [16:0] s;
    logic [15:0] lo;
    logic [15:0] bx;
    logic [15:0] r;
    logic        cin;
    logic [3:0]  fl;
    mValid = 1'b0;
    if (vld) begin
      case (op)
        4'd0, 4'd1, 4'd2, 4'd3, 4'd11: begin
          bx  = (op == 4'd2 || op == 4'd3 || op == 4'd11) ? ~b : b;
          cin = (op == 4'd0) ? 1'b0 : (op == 4'd2 || op == 4'd11) ? 1'b1 : mArith[0];
          s   = {1'b0, a} + {1'b0, bx} + {16'd0, cin};
          lo  = {1'b0, a[14:0]} + {1'b0, bx[14:0]} + {15'd0, cin};
          r   = s[15:0];
          fl  = {lo[15] ^ s[16], r[15], (r == 16'd0), s[16]};
          if (op == 4'd11) mCmp = fl;
          else begin mArith = fl; mRes = r; mValid = 1'b1; end
        end
        4'd4, 4'd5, 4'd6, 4'd7, 4'd8: begin
          r = (op == 4'd4) ? b : (op == 4'd5) ? (a & b) : (op == 4'd6) ? (a | b) :
              (op == 4'd7) ? (a ^ b) : ~b;
          mArith[2] = r[15]; mArith[1] = (r == 16'd0);
          mRes = r; mValid = 1'b1;
        end
        4'd9, 4'd10: begin
          r = (op == 4'd9) ? {a[14:0], mArith[0]} : {mArith[0], a[15:1]};
          mArith[0] = (op == 4'd9) ? a[15] : a[0];
          mArith[2] = r[15]; mArith[1] = (r == 16'd0);
          mRes = r; mValid = 1'b1;
        end
        4'd12: begin
          r = a & b;
          mCmp = {1'b0, r[15], (r == 16'd0), 1'b0};
        end
        default: ;
      endcase
    end
  endtask

  // Driver: one operation per cycle, pushes the expected outcome
  task automatic doOp(input logic vld, input logic [3:0] op,
                      input logic [15:0] a, input logic [15:0] b, input string tag);
    @(negedge clk);
    valid = vld; opCode = op; opA = a; opB = b;
    modelStep(vld, op, a, b);
    expQ.push_back({mRes, mValid, mArith, mCmp, 12'd0});
    tagQ.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    valid = 1'b0;
  endtask

  function automatic logic condModel(input logic sel, input logic [3:0] code);
    logic [3:0] f;
    f = sel ? mCmp : mArith;
    case (code)
      4'd0: return f[1];
      4'd1: return ~f[1];
      4'd2: return f[0];
      4'd3: return ~f[0];
      4'd4: return f[2];
      4'd5: return ~f[2];
      4'd6: return f[3];
      4'd7: return f[2] ^ f[3];
      4'd8: return ~(f[2] ^ f[3]);
      default: return 1'b0;
    endcase
  endfunction

  task automatic checkCond(input logic sel, input logic [3:0] code, input string tag);
    logic e;
    @(negedge clk);
    valid = 1'b0; condSel = sel; condCode = code;
    #1;
    e = condModel(sel, code);
    checks++;
    if (condTrue !== e) begin
      fails++;
      $display("FAIL %s sel=%0d code=%0d: condTrue actual %b expected %b", tag, sel, code, condTrue, e);
    end
  endtask

  // Monitor: pops one expected item per operation after the clock edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        logic [36:0] it;
        string       tg;
        it = expQ.pop_front();
        tg = tagQ.pop_front();
        checks++;
        if (result !== it[36:21] || resultValid !== it[20] ||
            arithFlags !== it[19:16] || cmpFlags !== it[15:12]) begin
          fails++;
          $display("FAIL %s: actual res=%h vld=%b ar=%b cm=%b expected res=%h vld=%b ar=%b cm=%b",
                   tg, result, resultValid, arithFlags, cmpFlags,
                   it[36:21], it[20], it[19:16], it[15:12]);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset values
    checks++;
    if (result !== 16'd0 || resultValid !== 1'b0 || arithFlags !== 4'd0 || cmpFlags !== 4'd0) begin
      fails++;
      $display("FAIL R1: actual res=%h vld=%b ar=%b cm=%b expected all zero",
               result, resultValid, arithFlags, cmpFlags);
    end
    rstN = 1'b1;

    // R2 add with signed overflow, then unsigned wrap
    doOp(1, 4'd0, 16'h7FFF, 16'h0001, "R2 add ovf");
    doOp(1, 4'd0, 16'hFFFF, 16'h0001, "R2 add wrap");
    // R4 multiword add: carry left set, then low/high pair
    doOp(1, 4'd1, 16'h1234, 16'h0000, "R4 adc carry1");
    doOp(1, 4'd0, 16'hFFFF, 16'h0002, "R4 low word");
    doOp(1, 4'd1, 16'h0001, 16'h0002, "R4 high word");
    // R4/R8: clear arith carry, set compare carry, ADC must use arith carry
    doOp(1, 4'd0, 16'h0000, 16'h0000, "R4 clear carry");
    doOp(1, 4'd11, 16'h0005, 16'h0003, "R8 cmp ge");
    doOp(1, 4'd1, 16'h0000, 16'h0000, "R4 adc ignores cmp carry");
    // R3 subtract, carry as not borrow, overflow
    doOp(1, 4'd2, 16'h0005, 16'h0003, "R3 sub no borrow");
    doOp(1, 4'd2, 16'h8000, 16'h0001, "R3 sub ovf");
    doOp(1, 4'd2, 16'h0003, 16'h0005, "R3 sub borrow");
    doOp(1, 4'd3, 16'h000A, 16'h0003, "R4 sbb with borrow");
    doOp(1, 4'd3, 16'h000A, 16'h0003, "R4 sbb no borrow");
    // R5 force C and V high, then logic keeps them
    doOp(1, 4'd0, 16'h8000, 16'h8000, "R2 add c v z");
    doOp(1, 4'd5, 16'hF0F0, 16'h8F00, "R5 and");
    doOp(1, 4'd6, 16'h0000, 16'h0000, "R5 or zero");
    doOp(1, 4'd7, 16'hAAAA, 16'h5555, "R5 xor");
    doOp(1, 4'd4, 16'h1111, 16'h0042, "R5 mov");
    doOp(1, 4'd8, 16'h0000, 16'hFFFF, "R5 not");
    // R6 shifts through carry, overflow kept
    doOp(1, 4'd9, 16'h8001, 16'h0000, "R6 shl");
    doOp(1, 4'd9, 16'h4000, 16'h0000, "R6 shl carry in");
    doOp(1, 4'd10, 16'h0001, 16'h0000, "R6 shr");
    doOp(1, 4'd10, 16'h0000, 16'h0000, "R6 shr carry in");
    // R9 test
    doOp(1, 4'd12, 16'h8F00, 16'hF000, "R9 tst neg");
    doOp(1, 4'd12, 16'h00FF, 16'hFF00, "R9 tst zero");
    // R8 signed compare: -2 vs 1
    doOp(1, 4'd11, 16'hFFFE, 16'h0001, "R8 cmp signed lt");
    // R12 ignored operations
    doOp(1, 4'd13, 16'hFFFF, 16'hFFFF, "R12 op13");
    doOp(1, 4'd15, 16'h1234, 16'h0001, "R12 op15");
    doOp(0, 4'd0, 16'hFFFF, 16'hFFFF, "R12 valid low");
    // R7 result-producing op after idle
    doOp(1, 4'd0, 16'h0000, 16'h0000, "R7 zero result");
    doOp(1, 4'd2, 16'h0000, 16'h0001, "R7 neg result");
    idle();
    // R10/R11 conditions on both groups
    for (int c = 0; c < 16; c++) checkCond(1'b0, c[3:0], "R11 arith");
    for (int c = 0; c < 16; c++) checkCond(1'b1, c[3:0], "R10 cmp");
    doOp(1, 4'd11, 16'h0003, 16'h0003, "R8 cmp equal");
    idle();
    checkCond(1'b1, 4'd0, "R10 eq cmp");
    checkCond(1'b0, 4'd0, "R10 eq arith");
    checkCond(1'b1, 4'd8, "R11 ge cmp");
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule